// File: doc/BRIEF.md
# Chopper-Synchronous Two-Stage Decimator

This block turns a one-bit modulator stream into decimated words when the analog input path is chopped. The chopping moves the front-end offset and the low-frequency noise up to the chop frequency. A third-order comb-integrator stage with a short ratio of 16 runs at the bit rate. It settles within a few blocks, so it can keep up with the chop clock. Each of its words is then dechopped: the word is negated when the chop phase behind it was 1 and passed unchanged when the phase was 0. A first-order stage of ratio 16 sums the dechopped words. This stage cancels the offset, which now alternates in sign, and sets the total ratio to 256.

The sign applied to a first-stage word comes from the chop phase of the samples that formed that word. A word is formed from its own 16-sample block and the two blocks before it, so that is the window where the phase is taken. If the chop phase changed anywhere inside that window, the word holds samples from both phases. Such a word is dropped, and the last good dechopped word is used in its place. The chop clock must run at least twice the output word rate, and a chop half-period must cover at least four blocks so that some first-stage words are clean. The block has one clock. It takes one bit and one chop-phase sample on each rising edge.

Top module: `chop_decim`

A small three-state machine tracks how many earlier blocks have been seen since reset. Its states are HIST_NONE (no earlier block), HIST_ONE (one earlier block) and HIST_TWO (two earlier blocks, the steady state). Its transitions occur only on the last sample of a block: HIST_NONE to HIST_ONE, HIST_ONE to HIST_TWO, and HIST_TWO to itself.

## Requirements
- R1: Sample n is the bit taken on the n-th rising edge after reset is released, counting from 0. A 1 counts as +1 and a 0 counts as -1. Block m is samples 16m to 16m+15. The first-stage word of block m equals the sum over k = 0..45 of h(k)·x(16m+15-k), where h is the convolution of three 16-sample boxcars and samples before reset count as 0. Its magnitude never exceeds 4096.
- R2: The word of block m is clean only when the chop phase held a single value over every sample of block m and of the up to two blocks before it. Blocks before reset do not count.
- R3: A clean word is negated in two's complement when that phase is 1 and passed unchanged when it is 0.
- R4: A word that is not clean is replaced by the previous dechopped word, or by 0 if there is none yet.
- R5: Output word k equals the sum of the dechopped words of blocks 16k to 16k+15.
- R6: dout_vld is high for exactly one cycle, after edge 256k+257. dout holds its value between pulses.
- R7: During reset dout is 0 and dout_vld is 0. After reset the block history starts out empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Modulator bit, 1 = +1, 0 = -1 |
| chop_ph | input | 1 | Chop phase in force for this bit |
| dout | output | 18 | Decimated signed output word |
| dout_vld | output | 1 | One-cycle strobe for a new dout |

## Verification
The tightest coincidence is a chop edge that lands on the last sample of a block. In that one cycle, the block's own phase check has to see the change while the history register is also being shifted. One stimulus segment toggles the phase on exactly that sample. The bench model then expects the block to be dirty and the held word to be used. Random chop edges at arbitrary offsets, mixed with aligned toggles and full-scale inputs, cover the replacement and negation paths as they feed the 16-word sums.

// File: rtl/chop_decim_pkg.sv
package chop_decim_pkg;
    localparam int CIC_ORDER = 3;

    typedef enum logic [1:0] {
        HIST_NONE = 2'd0,
        HIST_ONE  = 2'd1,
        HIST_TWO  = 2'd2
    } hist_state_e;
endpackage

// File: rtl/sinc3_stage.sv
module sinc3_stage
    import chop_decim_pkg::*;
#(
    parameter int R_LOG2 = 4,
    parameter int W      = 2 + CIC_ORDER * R_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_in,
    output logic                blk_first,
    output logic                blk_last,
    output logic                y_vld,
    output logic signed [W-1:0] y
);
    logic [R_LOG2-1:0]   phase_cnt;
    logic signed [W-1:0] x_val;
    logic signed [W-1:0] integ   [CIC_ORDER];
    logic signed [W-1:0] integ_n [CIC_ORDER];
    logic signed [W-1:0] cdly    [CIC_ORDER];
    logic signed [W-1:0] comb_n  [CIC_ORDER];

    assign blk_first = (phase_cnt == '0);
    assign blk_last  = (phase_cnt == '1);
    assign x_val     = bit_in ? W'(1) : {W{1'b1}};

    // integrators include the current sample (no added delay)
    always_comb begin
        integ_n[0] = integ[0] + x_val;
        for (int j = 1; j < CIC_ORDER; j++)
            integ_n[j] = integ[j] + integ_n[j-1];
        comb_n[0] = integ_n[CIC_ORDER-1] - cdly[0];
        for (int j = 1; j < CIC_ORDER; j++)
            comb_n[j] = comb_n[j-1] - cdly[j];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_cnt <= '0;
            y_vld     <= 1'b0;
            y         <= '0;
            for (int j = 0; j < CIC_ORDER; j++) begin
                integ[j] <= '0;
                cdly[j]  <= '0;
            end
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
            y_vld     <= blk_last;
            for (int j = 0; j < CIC_ORDER; j++)
                integ[j] <= integ_n[j];
            if (blk_last) begin
                cdly[0] <= integ_n[CIC_ORDER-1];
                for (int j = 1; j < CIC_ORDER; j++)
                    cdly[j] <= comb_n[j-1];
                y <= comb_n[CIC_ORDER-1];
            end
        end
    end
endmodule

// File: rtl/dechop_unit.sv
module dechop_unit
    import chop_decim_pkg::*;
#(
    parameter int W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                chop,
    input  logic                blk_first,
    input  logic                blk_last,
    input  logic                y_vld,
    input  logic signed [W-1:0] y,
    output logic                clean_q,
    output logic                d_vld,
    output logic signed [W-1:0] d
);
    hist_state_e state, state_n;
    logic cur_ph, cur_u, blk_u, clean_n, ph_q;
    logic h1_u, h1_p, h2_u, h2_p;

    assign blk_u = cur_u && (chop == cur_ph);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= HIST_NONE;
        else        state <= state_n;
    end

    // transitions, taken on the last sample of a block
    always_comb begin
        state_n = state;
        if (blk_last) begin
            unique case (state)
                HIST_NONE: state_n = HIST_ONE;
                HIST_ONE:  state_n = HIST_TWO;
                HIST_TWO:  state_n = HIST_TWO;
                default:   state_n = HIST_NONE;
            endcase
        end
    end

    // outputs: cleanliness of the block now ending
    always_comb begin
        unique case (state)
            HIST_NONE: clean_n = blk_u;
            HIST_ONE:  clean_n = blk_u && h1_u && (h1_p == cur_ph);
            HIST_TWO:  clean_n = blk_u && h1_u && (h1_p == cur_ph)
                                 && h2_u && (h2_p == cur_ph);
            default:   clean_n = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ph  <= 1'b0;
            cur_u   <= 1'b0;
            h1_u    <= 1'b0;
            h1_p    <= 1'b0;
            h2_u    <= 1'b0;
            h2_p    <= 1'b0;
            clean_q <= 1'b0;
            ph_q    <= 1'b0;
            d_vld   <= 1'b0;
            d       <= '0;
        end else begin
            if (blk_first) begin
                cur_ph <= chop;
                cur_u  <= 1'b1;
            end else if (chop != cur_ph) begin
                cur_u <= 1'b0;
            end
            if (blk_last) begin
                h2_u    <= h1_u;
                h2_p    <= h1_p;
                h1_u    <= blk_u;
                h1_p    <= cur_ph;
                clean_q <= clean_n;
                ph_q    <= cur_ph;
            end
            d_vld <= y_vld;
            if (y_vld && clean_q)
                d <= ph_q ? -y : y;
        end
    end
endmodule

// File: rtl/boxcar_stage.sv
module boxcar_stage #(
    parameter int W_IN   = 14,
    parameter int R_LOG2 = 4,
    parameter int W_OUT  = W_IN + R_LOG2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    d_vld,
    input  logic signed [W_IN-1:0]  d,
    output logic                    dout_vld,
    output logic signed [W_OUT-1:0] dout
);
    logic [R_LOG2-1:0]       cnt;
    logic signed [W_OUT-1:0] acc, d_ext, sum_n;

    assign d_ext = {{(W_OUT-W_IN){d[W_IN-1]}}, d};
    assign sum_n = acc + d_ext;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            acc      <= '0;
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= 1'b0;
            if (d_vld) begin
                cnt <= cnt + 1'b1;
                if (cnt == '1) begin
                    dout     <= sum_n;
                    dout_vld <= 1'b1;
                    acc      <= '0;
                end else begin
                    acc <= sum_n;
                end
            end
        end
    end
endmodule

// File: rtl/chop_decim.sv
module chop_decim
    import chop_decim_pkg::*;
#(
    parameter  int R1_LOG2 = 4,
    parameter  int R2_LOG2 = 4,
    localparam int W1      = 2 + CIC_ORDER * R1_LOG2,
    localparam int W2      = W1 + R2_LOG2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_in,
    input  logic          chop_ph,
    output logic [W2-1:0] dout,
    output logic          dout_vld
);
    logic                 blk_first, blk_last, s1_vld, dc_clean, dc_vld;
    logic signed [W1-1:0] s1_y, dc_d;
    logic signed [W2-1:0] s2_out;

    sinc3_stage #(.R_LOG2(R1_LOG2), .W(W1)) u_s1 (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in),
        .blk_first(blk_first), .blk_last(blk_last),
        .y_vld(s1_vld), .y(s1_y)
    );

    dechop_unit #(.W(W1)) u_dc (
        .clk(clk), .rst_n(rst_n), .chop(chop_ph),
        .blk_first(blk_first), .blk_last(blk_last),
        .y_vld(s1_vld), .y(s1_y),
        .clean_q(dc_clean), .d_vld(dc_vld), .d(dc_d)
    );

    boxcar_stage #(.W_IN(W1), .R_LOG2(R2_LOG2), .W_OUT(W2)) u_s2 (
        .clk(clk), .rst_n(rst_n), .d_vld(dc_vld), .d(dc_d),
        .dout_vld(dout_vld), .dout(s2_out)
    );

    assign dout = s2_out;
endmodule

// File: rtl/chop_decim_chk.sv
module chop_decim_chk #(
    parameter int W1      = 14,
    parameter int R1_LOG2 = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          y1_vld,
    input logic [W1-1:0] y1,
    input logic          clean,
    input logic          d_vld,
    input logic [W1-1:0] d,
    input logic          dout_vld
);
    localparam int LIM = 2 ** (3 * R1_LOG2);

    assert_y1_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        y1_vld |-> ($signed(y1) <= LIM && $signed(y1) >= -LIM));

    assert_dechop_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        y1_vld |=> d_vld);

    assert_dirty_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (y1_vld && !clean) |=> (d == $past(d)));

    assert_sum_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> $past(d_vld));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |=> !dout_vld);
endmodule

bind chop_decim chop_decim_chk #(.W1(W1), .R1_LOG2(R1_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .y1_vld(s1_vld), .y1(s1_y),
    .clean(dc_clean), .d_vld(dc_vld), .d(dc_d), .dout_vld(dout_vld)
);

// File: tb/chop_decim_test.sv
`timescale 1ns/1ps
module chop_decim_test;
    localparam int NMAX = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        chop_ph = 1'b0;
    logic [17:0] dout;
    logic        dout_vld;

    int xs [NMAX];
    int cs [NMAX];
    int n_smp = 0;
    int n_chk = 0;
    int n_fail = 0;
    int hold_exp = 0;
    bit finished = 0;
    logic cur_c = 1'b0;

    chop_decim uut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .chop_ph(chop_ph),
        .dout(dout), .dout_vld(dout_vld)
    );

    always #4 clk = ~clk;

    function automatic int hcoef(int k);
        int c = 0;
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                if (k - a - b >= 0 && k - a - b < 16) c++;
        return c;
    endfunction

    function automatic int y1_model(int m);
        int s = 0;
        for (int k = 0; k < 46; k++)
            if (16*m + 15 - k >= 0) s += hcoef(k) * xs[16*m + 15 - k];
        return s;
    endfunction

    function automatic bit clean_model(int m);
        int lo = (m >= 2) ? 16*(m-2) : 0;
        for (int i = lo; i <= 16*m + 15; i++)
            if (cs[i] != cs[16*m + 15]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int out_model(int k);
        int dv = 0;
        int sum = 0;
        for (int m = 0; m <= 16*k + 15; m++) begin
            if (clean_model(m)) dv = (cs[16*m+15] != 0) ? -y1_model(m) : y1_model(m);
            if (m >= 16*k) sum += dv;
        end
        return sum;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (sample %0d)", tag, act, exp, n_smp);
        end
    endtask

    task automatic step(bit b, logic c, string tag);
        int e;
        bit vexp;
        bit_in  = b;
        chop_ph = c;
        xs[n_smp] = b ? 1 : -1;
        cs[n_smp] = int'(c);
        @(posedge clk);
        n_smp++;
        @(negedge clk);
        e = n_smp - 1;
        vexp = (e >= 257) && ((e - 257) % 256 == 0);
        if (vexp) begin
            hold_exp = out_model((e - 257) / 256);
            check(dout_vld === 1'b1, {tag, " R6 strobe"}, int'(dout_vld), 1);
            check($signed(dout) == hold_exp, {tag, " R5 word"}, $signed(dout), hold_exp);
        end else begin
            check(dout_vld === 1'b0, {tag, " R6 no strobe"}, int'(dout_vld), 0);
            check($signed(dout) == hold_exp, {tag, " R6 hold"}, $signed(dout), hold_exp);
        end
    endtask

    initial begin
        int unsigned seed;
        int gap;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        check(dout === 18'd0, "R7 reset dout", int'(dout), 0);
        check(dout_vld === 1'b0, "R7 reset strobe", int'(dout_vld), 0);
        rst_n = 1'b1;
        // A: full-scale positive, steady phase 0
        for (int i = 0; i < 512; i++) step(1'b1, 1'b0, "R1");
        // B: random density, phase toggles every 64 samples on block edges
        for (int i = 0; i < 1024; i++) begin
            if (n_smp % 64 == 0) cur_c = ~cur_c;
            step(($urandom % 4) != 0, cur_c, "R3");
        end
        // C: phase changes on the last sample of a block
        for (int i = 0; i < 1024; i++) begin
            if (n_smp % 64 == 63) cur_c = ~cur_c;
            step(($urandom % 3) != 0, cur_c, "R2");
        end
        // D: random bits, phase edges at random offsets
        gap = 50;
        for (int i = 0; i < 1536; i++) begin
            gap--;
            if (gap == 0) begin
                cur_c = ~cur_c;
                gap = 40 + int'($urandom % 81);
            end
            step($urandom % 2 == 1, cur_c, "R4");
        end
        // E: full-scale negative, aligned toggles
        for (int i = 0; i < 516; i++) begin
            if (n_smp % 64 == 0) cur_c = ~cur_c;
            step(1'b0, cur_c, "R3");
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule